// File: doc/BRIEF.md
# BCD Calendar Clock with Snapshot Registers

This block keeps the time of day and the calendar in packed BCD: seconds, minutes, hours on a 24-hour dial, a free-running day-of-week, the day of the month, the month and a two-digit year. Its counters advance once per second. The second comes from dividing a 32.768 kHz time-base strobe, which arrives as a single-cycle enable on the system clock. A two-to-four-digit-year overflow raises a sticky century flag. Month lengths follow the rule that every year divisible by four is a leap year. That rule is exact for 2000 through 2099.

Software never touches the running counters directly. Each time field has a holding register on the bus side. Raising the capture bit copies the live counters into the holding registers, so the returned time cannot change during a multi-byte read. Raising the freeze bit stops the counters. Lowering the freeze bit loads the holding registers into the counters. A configuration byte stores an oscillator-stop bit and calibration trim bits. A control bit routes a 512 Hz square wave, derived from the time base, to an output pin.

The bus is a simple synchronous register port. Reads return their data one clock after the read strobe.

Top module: `bcd_snapshot_clock`

## Requirements
- R1: After reset, address 0 reads 0x00. Addresses 2..8 read 0x00, 0x00, 0x00, 0x01, 0x01, 0x01, 0x00 (sec, min, hour, weekday, date, month, year).
- R2: Seconds and minutes count 00..59 in BCD, and hours count 00..23. A lower digit of 9 carries into the tens nibble, and 23:59:59 rolls to 00:00:00.
- R3: Weekday (address 5) steps 1..7 and wraps to 1 on each midnight, with no tie to the date.
- R4: Date (address 6) wraps to 01 after the last day of the month. Month (address 7) then advances. The last day is 30 for months 04, 06, 09 and 11. February ends on 29 when the BCD year is divisible by four (00 included) and on 28 otherwise. All other months end on 31.
- R5: A year rollover from 99 to 00 sets bit 6 of address 0. A read of address 0 returns the flag and then clears it. A bus write cannot set the flag.
- R6: Writing bit 0 of address 0 from 0 to 1 copies the counters into the holding registers one clock later. Rewriting it while it is already 1 copies nothing.
- R7: If a one-second advance lands in the capture cycle, the holding registers receive the advanced time.
- R8: While bit 1 of address 0 is 1, one-second advances are discarded and not queued. Clearing it loads the holding registers into the counters. An advance in that same cycle is discarded.
- R9: Bit 7 of address 1 resets to 1. While it is 1, the time-base divider and the counters stand still.
- R10: When bit 2 of address 0 is 1, `cal_out` equals bit CAL_BIT of the time-base divider and so toggles every 32 base strobes. When that bit is 0, `cal_out` is 0.
- R11: Address 1 stores all eight written bits and reads them back.
- R12: Read data appears on `bus_rdata` the cycle after `bus_rd`. Addresses 9..15 read 0x00, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| base_tick | input | 1 | One-cycle strobe at the 32.768 kHz time-base rate |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| cal_out | output | 1 | 512 Hz calibration square wave, low when disabled |

## Verification
The risky coincidence is a one-second advance falling in the same clock as a capture or a commit. The bench drives the time base itself and keeps the divider phase aligned. It can therefore place the final strobe of a second exactly in the cycle after a capture write or a freeze-release write. For the capture case it expects the advanced seconds value in the holding copy. For the commit case it expects exactly the written value, with no extra second.

// File: rtl/calclk_pkg.sv
package calclk_pkg;

    localparam int BCD_W  = 8;
    localparam int ADDR_W = 4;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL  = 4'h0,
        A_CFG   = 4'h1,
        A_SEC   = 4'h2,
        A_MIN   = 4'h3,
        A_HOUR  = 4'h4,
        A_WDAY  = 4'h5,
        A_DATE  = 4'h6,
        A_MONTH = 4'h7,
        A_YEAR  = 4'h8
    } reg_addr_e;

    typedef struct packed {
        logic [BCD_W-1:0] year;
        logic [BCD_W-1:0] month;
        logic [BCD_W-1:0] date;
        logic [BCD_W-1:0] wday;
        logic [BCD_W-1:0] hour;
        logic [BCD_W-1:0] min;
        logic [BCD_W-1:0] sec;
    } cal_time_t;

    localparam cal_time_t TIME_RST = '{year: 8'h00, month: 8'h01, date: 8'h01,
                                       wday: 8'h01, hour: 8'h00, min: 8'h00,
                                       sec: 8'h00};

    localparam logic [BCD_W-1:0] CFG_RST = 8'h80;

    // One BCD step: returns {wrapped, next value}
    function automatic logic [BCD_W:0] bcd_step(input logic [BCD_W-1:0] v,
                                                input logic [BCD_W-1:0] last,
                                                input logic [BCD_W-1:0] first);
        logic [BCD_W:0] r;
        if (v == last)
            r = {1'b1, first};
        else if (v[3:0] == 4'h9)
            r = {1'b0, v[7:4] + 4'h1, 4'h0};
        else
            r = {1'b0, v + 8'h01};
        return r;
    endfunction

    function automatic logic is_leap(input logic [BCD_W-1:0] yr);
        logic lo_ok;
        if (yr[4] == 1'b0)
            lo_ok = (yr[3:0] == 4'h0) || (yr[3:0] == 4'h4) || (yr[3:0] == 4'h8);
        else
            lo_ok = (yr[3:0] == 4'h2) || (yr[3:0] == 4'h6);
        return lo_ok;
    endfunction

    function automatic logic [BCD_W-1:0] month_last(input logic [BCD_W-1:0] mo,
                                                    input logic [BCD_W-1:0] yr);
        logic [BCD_W-1:0] d;
        case (mo)
            8'h02:                      d = is_leap(yr) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: d = 8'h30;
            default:                    d = 8'h31;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/calclk_prescale.sv
module calclk_prescale #(
    parameter int PRESCALE_W = 15,
    parameter int CAL_BIT    = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic base_tick,
    input  logic halt,
    input  logic cal_en,
    output logic sec_tick,
    output logic cal_out
);
    logic [PRESCALE_W-1:0] div_q;
    logic                  run;

    assign run      = base_tick & ~halt;
    assign sec_tick = run & (&div_q);
    assign cal_out  = cal_en & div_q[CAL_BIT];

    always_ff @(posedge clk) begin
        if (rst)
            div_q <= '0;
        else if (run)
            div_q <= div_q + 1'b1;
    end
endmodule

// File: rtl/calclk_chain.sv
module calclk_chain
    import calclk_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      sec_tick,
    input  logic      freeze,
    input  logic      commit,
    input  cal_time_t load_val,
    output cal_time_t now_q,
    output cal_time_t upcoming,
    output logic      century
);
    logic [BCD_W:0] s_st, m_st, h_st, d_st, dt_st, mo_st, y_st;
    logic           c_min, c_hr, c_day, c_mon, c_yr, adv;
    cal_time_t      stepped;

    assign s_st  = bcd_step(now_q.sec,   8'h59, 8'h00);
    assign m_st  = bcd_step(now_q.min,   8'h59, 8'h00);
    assign h_st  = bcd_step(now_q.hour,  8'h23, 8'h00);
    assign d_st  = bcd_step(now_q.wday,  8'h07, 8'h01);
    assign dt_st = bcd_step(now_q.date,  month_last(now_q.month, now_q.year), 8'h01);
    assign mo_st = bcd_step(now_q.month, 8'h12, 8'h01);
    assign y_st  = bcd_step(now_q.year,  8'h99, 8'h00);

    assign c_min = s_st[BCD_W];
    assign c_hr  = c_min & m_st[BCD_W];
    assign c_day = c_hr  & h_st[BCD_W];
    assign c_mon = c_day & dt_st[BCD_W];
    assign c_yr  = c_mon & mo_st[BCD_W];

    always_comb begin
        stepped.sec   = s_st[BCD_W-1:0];
        stepped.min   = c_min ? m_st[BCD_W-1:0]  : now_q.min;
        stepped.hour  = c_hr  ? h_st[BCD_W-1:0]  : now_q.hour;
        stepped.wday  = c_day ? d_st[BCD_W-1:0]  : now_q.wday;
        stepped.date  = c_day ? dt_st[BCD_W-1:0] : now_q.date;
        stepped.month = c_mon ? mo_st[BCD_W-1:0] : now_q.month;
        stepped.year  = c_yr  ? y_st[BCD_W-1:0]  : now_q.year;
    end

    assign adv      = sec_tick & ~freeze;
    assign upcoming = commit ? load_val : (adv ? stepped : now_q);
    assign century  = adv & ~commit & c_yr & y_st[BCD_W];

    always_ff @(posedge clk) begin
        if (rst)
            now_q <= TIME_RST;
        else
            now_q <= upcoming;
    end
endmodule

// File: rtl/calclk_regs.sv
module calclk_regs
    import calclk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BCD_W-1:0]  bus_wdata,
    input  cal_time_t         upcoming,
    input  logic              century,
    output cal_time_t         hold_q,
    output logic              w_bit,
    output logic              commit,
    output logic              osc_dis,
    output logic              cal_en,
    output logic [BCD_W-1:0]  bus_rdata
);
    logic             r_bit, r_d, w_d, cf, capture;
    logic [BCD_W-1:0] cfg_q;
    logic [BCD_W-1:0] rd_mux;

    assign capture = r_bit & ~r_d;
    assign commit  = w_d & ~w_bit;
    assign osc_dis = cfg_q[BCD_W-1];

    always_comb begin
        case (bus_addr)
            A_CTRL:  rd_mux = {1'b0, cf, 3'b000, cal_en, w_bit, r_bit};
            A_CFG:   rd_mux = cfg_q;
            A_SEC:   rd_mux = hold_q.sec;
            A_MIN:   rd_mux = hold_q.min;
            A_HOUR:  rd_mux = hold_q.hour;
            A_WDAY:  rd_mux = hold_q.wday;
            A_DATE:  rd_mux = hold_q.date;
            A_MONTH: rd_mux = hold_q.month;
            A_YEAR:  rd_mux = hold_q.year;
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_bit     <= 1'b0;
            r_d       <= 1'b0;
            w_bit     <= 1'b0;
            w_d       <= 1'b0;
            cal_en    <= 1'b0;
            cf        <= 1'b0;
            cfg_q     <= CFG_RST;
            hold_q    <= TIME_RST;
            bus_rdata <= '0;
        end else begin
            r_d <= r_bit;
            w_d <= w_bit;
            if (bus_wr) begin
                case (bus_addr)
                    A_CTRL:  {cal_en, w_bit, r_bit} <= bus_wdata[2:0];
                    A_CFG:   cfg_q        <= bus_wdata;
                    A_SEC:   hold_q.sec   <= bus_wdata;
                    A_MIN:   hold_q.min   <= bus_wdata;
                    A_HOUR:  hold_q.hour  <= bus_wdata;
                    A_WDAY:  hold_q.wday  <= bus_wdata;
                    A_DATE:  hold_q.date  <= bus_wdata;
                    A_MONTH: hold_q.month <= bus_wdata;
                    A_YEAR:  hold_q.year  <= bus_wdata;
                    default: ;
                endcase
            end
            if (capture)
                hold_q <= upcoming;
            if (century)
                cf <= 1'b1;
            else if (bus_rd && bus_addr == A_CTRL)
                cf <= 1'b0;
            if (bus_rd)
                bus_rdata <= rd_mux;
        end
    end
endmodule

// File: rtl/bcd_snapshot_clock.sv
module bcd_snapshot_clock
    import calclk_pkg::*;
#(
    parameter int PRESCALE_W = 15,
    parameter int CAL_BIT    = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              base_tick,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BCD_W-1:0]  bus_wdata,
    output logic [BCD_W-1:0]  bus_rdata,
    output logic              cal_out
);
    cal_time_t cnt_q, cnt_nx, hold_q;
    logic      sec_tick, century, w_bit, commit, osc_dis, cal_en;

    calclk_prescale #(.PRESCALE_W(PRESCALE_W), .CAL_BIT(CAL_BIT)) u_pre (
        .clk      (clk),
        .rst      (rst),
        .base_tick(base_tick),
        .halt     (osc_dis),
        .cal_en   (cal_en),
        .sec_tick (sec_tick),
        .cal_out  (cal_out)
    );

    calclk_chain u_chain (
        .clk     (clk),
        .rst     (rst),
        .sec_tick(sec_tick),
        .freeze  (w_bit),
        .commit  (commit),
        .load_val(hold_q),
        .now_q   (cnt_q),
        .upcoming(cnt_nx),
        .century (century)
    );

    calclk_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .upcoming (cnt_nx),
        .century  (century),
        .hold_q   (hold_q),
        .w_bit    (w_bit),
        .commit   (commit),
        .osc_dis  (osc_dis),
        .cal_en   (cal_en),
        .bus_rdata(bus_rdata)
    );
endmodule

// File: rtl/bcd_snapshot_clock_chk.sv
module bcd_snapshot_clock_chk
    import calclk_pkg::*;
(
    input logic      clk,
    input logic      rst,
    input logic      base_tick,
    input logic      cal_out,
    input logic      cal_en,
    input logic      w_bit,
    input logic      commit,
    input logic      osc_dis,
    input logic      century,
    input cal_time_t cnt
);
    AST_SEC_BCD: assert property (@(posedge clk) disable iff (rst)
        (cnt.sec[3:0] <= 4'h9) && (cnt.sec < 8'h60)); // R2

    AST_WDAY_RANGE: assert property (@(posedge clk) disable iff (rst)
        (cnt.wday >= 8'h01) && (cnt.wday <= 8'h07)); // R3

    AST_CENTURY_WRAP: assert property (@(posedge clk) disable iff (rst)
        century |=> (cnt.year == 8'h00) && (cnt.month == 8'h01)); // R5

    AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (rst)
        w_bit |=> $stable(cnt)); // R8

    AST_OSC_HALT: assert property (@(posedge clk) disable iff (rst)
        (osc_dis && !commit) |=> $stable(cnt)); // R9

    AST_CAL_QUIET: assert property (@(posedge clk) disable iff (rst)
        (cal_en && $past(cal_en) && !$past(base_tick)) |-> $stable(cal_out)); // R10
endmodule

bind bcd_snapshot_clock bcd_snapshot_clock_chk chk_i (
    .clk      (clk),
    .rst      (rst),
    .base_tick(base_tick),
    .cal_out  (cal_out),
    .cal_en   (cal_en),
    .w_bit    (w_bit),
    .commit   (commit),
    .osc_dis  (osc_dis),
    .century  (century),
    .cnt      (cnt_q)
);

// File: tb/bcd_snapshot_clock_tb.sv
module bcd_snapshot_clock_tb_top;
    localparam int CLK_P   = 10;
    localparam int PRE_W   = 6;
    localparam int PER_SEC = 1 << PRE_W;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       base_tick = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       cal_out;

    int n_total = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic       rd_seen = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    bcd_snapshot_clock #(.PRESCALE_W(PRE_W), .CAL_BIT(5)) dut_i (
        .clk(clk), .rst(rst), .base_tick(base_tick),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cal_out(cal_out)
    );

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_total++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", tag, got, exp);
        end
    endtask

    // Monitor: pops expected read data in the cycle after each read strobe
    always @(posedge clk) rd_seen <= bus_rd;
    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                n_total++; n_fail++;
                $display("FAIL R12 unexpected read actual=%02h expected=none", bus_rdata);
            end else begin
                check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
            end
        end
    end

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk); bus_rd = 1'b1; bus_addr = a;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(negedge clk); bus_rd = 1'b0;
    endtask

    task automatic strobes(input int n);
        @(negedge clk); base_tick = 1'b1;
        repeat (n) @(negedge clk);
        base_tick = 1'b0;
    endtask

    task automatic secs(input int n);
        strobes(n * PER_SEC);
    endtask

    task automatic snap();
        wr(4'h0, 8'h01);
        wr(4'h0, 8'h00);
    endtask

    task automatic set_time(input logic [7:0] y, mo, dt, wd, h, mi, s);
        wr(4'h0, 8'h02);
        wr(4'h2, s); wr(4'h3, mi); wr(4'h4, h); wr(4'h5, wd);
        wr(4'h6, dt); wr(4'h7, mo); wr(4'h8, y);
        wr(4'h0, 8'h00);
    endtask

    task automatic read_time(input logic [7:0] y, mo, dt, wd, h, mi, s, input string tag);
        rd(4'h2, s,  tag); rd(4'h3, mi, tag); rd(4'h4, h,  tag); rd(4'h5, wd, tag);
        rd(4'h6, dt, tag); rd(4'h7, mo, tag); rd(4'h8, y,  tag);
    endtask

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            n_total++; n_fail++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state, R9 config reset, R12 unused address
        rd(4'h0, 8'h00, "R1 ctrl");
        rd(4'h1, 8'h80, "R9 cfg reset");
        read_time(8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00, "R1 time reset");
        rd(4'h9, 8'h00, "R12 unused read");

        // R9: oscillator stopped, no time advance
        secs(2);
        snap();
        rd(4'h2, 8'h00, "R9 halted seconds");

        // R11 config storage; R12 ignored write
        wr(4'h1, 8'h2A);
        rd(4'h1, 8'h2A, "R11 cfg readback");
        wr(4'h9, 8'h55);
        rd(4'h9, 8'h00, "R12 unused write");

        // R2 R3 R4: leap day in year 00, weekday 7 wraps to 1
        set_time(8'h00, 8'h02, 8'h28, 8'h07, 8'h23, 8'h59, 8'h59);
        secs(1); snap();
        read_time(8'h00, 8'h02, 8'h29, 8'h01, 8'h00, 8'h00, 8'h00, "R4 leap feb");

        // R4 non-leap February, R3 weekday 3 to 4
        set_time(8'h01, 8'h02, 8'h28, 8'h03, 8'h23, 8'h59, 8'h59);
        secs(1); snap();
        read_time(8'h01, 8'h03, 8'h01, 8'h04, 8'h00, 8'h00, 8'h00, "R4 plain feb");

        // R4 thirty-day month
        set_time(8'h23, 8'h04, 8'h30, 8'h05, 8'h23, 8'h59, 8'h59);
        secs(1); snap();
        read_time(8'h23, 8'h05, 8'h01, 8'h06, 8'h00, 8'h00, 8'h00, "R4 april");

        // R2 hour nibble carry 09 -> 10
        set_time(8'h23, 8'h05, 8'h01, 8'h06, 8'h09, 8'h59, 8'h59);
        secs(1); snap();
        read_time(8'h23, 8'h05, 8'h01, 8'h06, 8'h10, 8'h00, 8'h00, "R2 hour carry");

        // R5 century rollover, read-to-clear, not writable
        set_time(8'h99, 8'h12, 8'h31, 8'h02, 8'h23, 8'h59, 8'h59);
        secs(1); snap();
        read_time(8'h00, 8'h01, 8'h01, 8'h03, 8'h00, 8'h00, 8'h00, "R5 year wrap");
        rd(4'h0, 8'h40, "R5 flag set");
        rd(4'h0, 8'h00, "R5 flag cleared");
        wr(4'h0, 8'h40);
        rd(4'h0, 8'h00, "R5 flag not writable");
        wr(4'h0, 8'h00);

        // R8 freeze drops ticks
        wr(4'h0, 8'h02);
        secs(2);
        wr(4'h0, 8'h03);
        rd(4'h2, 8'h00, "R8 frozen");
        wr(4'h0, 8'h02);
        wr(4'h0, 8'h00);
        secs(1); snap();
        rd(4'h2, 8'h01, "R8 not queued");

        // R6 no recapture while R stays 1
        wr(4'h0, 8'h01);
        secs(1);
        wr(4'h0, 8'h01);
        rd(4'h2, 8'h01, "R6 held R");
        wr(4'h0, 8'h00);
        snap();
        rd(4'h2, 8'h02, "R6 fresh capture");

        // R7 tick in the capture cycle
        strobes(PER_SEC - 1);
        @(negedge clk); bus_wr = 1'b1; bus_addr = 4'h0; bus_wdata = 8'h01;
        @(negedge clk); bus_wr = 1'b0; base_tick = 1'b1;
        @(negedge clk); base_tick = 1'b0;
        rd(4'h2, 8'h03, "R7 pending tick");
        wr(4'h0, 8'h00);

        // R8 tick in the commit cycle is dropped
        wr(4'h0, 8'h02);
        wr(4'h2, 8'h30);
        strobes(PER_SEC - 1);
        @(negedge clk); bus_wr = 1'b1; bus_addr = 4'h0; bus_wdata = 8'h00;
        @(negedge clk); bus_wr = 1'b0; base_tick = 1'b1;
        @(negedge clk); base_tick = 1'b0;
        snap();
        rd(4'h2, 8'h30, "R8 commit wins");
        rd(4'h3, 8'h00, "R8 commit minutes");

        // R10 calibration output
        wr(4'h0, 8'h04);
        check("R10 cal phase0", {7'd0, cal_out}, 8'h00);
        strobes(32);
        check("R10 cal high", {7'd0, cal_out}, 8'h01);
        strobes(32);
        check("R10 cal low", {7'd0, cal_out}, 8'h00);
        strobes(32);
        check("R10 cal high again", {7'd0, cal_out}, 8'h01);
        wr(4'h0, 8'h00);
        check("R10 cal disabled", {7'd0, cal_out}, 8'h00);
        strobes(32);

        repeat (4) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_total++; n_fail++;
            $display("FAIL R12 pending reads actual=%0d expected=0", exp_q.size());
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end
endmodule